// File: doc/BRIEF.md
# Processor Control and Status Register

This block holds the 32-bit control and status word of a small processor core. Software changes it through a move-to-control-register write port. That port carries a condition flag, and a write whose condition is false does nothing. The execution units report saturation events on a per-cycle input, which sets a sticky bit one cycle late. The interrupt logic pulses a strobe when an interrupt is taken and another when it returns. The register saves and restores the global interrupt enable around these strobes, so interrupts can nest.

The read port always shows the full word. Bits 31:16 hold a fixed identity value. Bits 15:10 always read zero. Bit 8 reports the endian mode fixed at build time. Two 3-bit cache mode fields keep only their legal codes. The global enable bit also drives the interrupt gate output, which the interrupt controller uses to mask maskable requests.

Top module: `csr_ctrl_status`

## Requirements
- R1: Synchronous active-high reset gives rd_data = 0x0203_0100 with the default parameters, and irq_enable = 0.
- R2: Bits 31:16 read as 0x0203 at all times. Writes to them have no effect.
- R3: Bits 15:10 read as zero for every written value.
- R4: Bit 8 reads 1 when LITTLE_ENDIAN = 1 (the default) and 0 when LITTLE_ENDIAN = 0. Writes to it have no effect.
- R5: Bits 7:5 and 4:2 are two independent mode fields. Each takes a written code only when that code is 3'b000 or 3'b010. Any other code leaves the field unchanged. Both fields reset to 3'b000.
- R6: A saturation event sampled at clock edge k makes bit 9 read 1 after edge k+1, and not after edge k.
- R7: Bit 9 clears only through an effective write (wr_en and wr_cond both 1) with wr_data[9] = 0. Writing 1 to bit 9 does not set it.
- R8: When a delayed saturation set and a software clear of bit 9 reach the same edge, bit 9 ends up 1.
- R9: A write with wr_cond = 0 changes no bit of the register.
- R10: On irq_take, bit 1 takes the old value of bit 0, and bit 0 becomes 0. This has priority over irq_return and over a write of bits 1:0 in the same cycle. Other fields of such a write still apply.
- R11: On irq_return without irq_take, bit 0 takes the value of bit 1, and bit 1 keeps its value. This has priority over a write of bits 1:0 in the same cycle.
- R12: An effective write with no interrupt strobe loads bits 1 and 0 from wr_data[1:0]. irq_enable always equals bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write instruction issued this cycle |
| wr_cond | input | 1 | Condition of the write instruction; 0 cancels the write |
| wr_data | input | 32 | Value written |
| sat_evt | input | 1 | Saturation performed by a unit this cycle |
| irq_take | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| rd_data | output | 32 | Current register word |
| irq_enable | output | 1 | Global interrupt enable to the interrupt controller |

## Verification
The bench builds the default configuration as u0, with identity 0x0203 and little endian. It also builds a second copy with LITTLE_ENDIAN = 0, so that both values of bit 8 can be checked. The 3-bit mode fields are small enough to sweep in full: every pair of codes is written to both fields, and all 64 values of the power-down bits are written. The saturation pipeline and the enable save and restore are driven edge by edge. This covers the one-cycle delay, set-over-clear, cancelled writes, nesting, and strobe priority.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned NUM_MODE_FIELDS = 2;

  typedef struct packed {
    logic [15:0]       ident;
    logic [5:0]        pwr_ctl;
    logic              sat;
    logic              endian;
    logic [MODE_W-1:0] prog_mode;
    logic [MODE_W-1:0] data_mode;
    logic              prev_en;
    logic              glob_en;
  } csr_word_t;

  // least significant bit of each mode field, index 0 = data, 1 = program
  function automatic int unsigned mode_lsb(input int unsigned idx);
    return (idx == 0) ? 2 : 2 + MODE_W;
  endfunction
endpackage

// File: rtl/csr_sat_sticky.sv
module csr_sat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic sat_evt,
  input  logic clr_req,
  output logic sat_pend,
  output logic sat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sat_pend <= 1'b0;
      sat_q    <= 1'b0;
    end else begin
      sat_pend <= sat_evt;
      if (sat_pend)
        sat_q <= 1'b1;
      else if (clr_req)
        sat_q <= 1'b0;
    end
  end

  // R6
  sat_delay_chk: assert property (@(posedge clk) disable iff (rst)
    sat_evt |=> ##1 sat_q);

  // R8
  sat_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_pend && clr_req) |=> sat_q);

  // R7
  sat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !sat_pend) |=> !sat_q);
endmodule

// File: rtl/csr_mode_field.sv
module csr_mode_field #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] CODE_A = '0,
  parameter logic [W-1:0] CODE_B = W'(2)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_ok,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] field_q
);
  logic legal;
  assign legal = (wr_val == CODE_A) || (wr_val == CODE_B);

  always_ff @(posedge clk) begin
    if (rst)
      field_q <= CODE_A;
    else if (wr_ok && legal)
      field_q <= wr_val;
  end

  // R5
  mode_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !legal) |=> $stable(field_q));

  // R5
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (field_q == CODE_A || field_q == CODE_B));
endmodule

// File: rtl/csr_irq_enable.sv
module csr_irq_enable (
  input  logic clk,
  input  logic rst,
  input  logic wr_ok,
  input  logic wr_glob,
  input  logic wr_prev,
  input  logic take,
  input  logic ret,
  output logic glob_q,
  output logic prev_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      glob_q <= 1'b0;
      prev_q <= 1'b0;
    end else if (take) begin
      prev_q <= glob_q;
      glob_q <= 1'b0;
    end else if (ret) begin
      glob_q <= prev_q;
    end else if (wr_ok) begin
      glob_q <= wr_glob;
      prev_q <= wr_prev;
    end
  end

  // R10
  irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (!glob_q && prev_q == $past(glob_q)));

  // R11
  irq_return_chk: assert property (@(posedge clk) disable iff (rst)
    (ret && !take) |=> (glob_q == $past(prev_q) && $stable(prev_q)));
endmodule

// File: rtl/csr_ctrl_status.sv
module csr_ctrl_status #(
  parameter logic [15:0] ID_VALUE      = 16'h0203,
  parameter bit          LITTLE_ENDIAN = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_cond,
  input  logic [31:0] wr_data,
  input  logic        sat_evt,
  input  logic        irq_take,
  input  logic        irq_return,
  output logic [31:0] rd_data,
  output logic        irq_enable
);
  import csr_pkg::*;

  localparam int unsigned SAT_BIT = 9;

  logic wr_ok;
  logic sat_pend, sat_q;
  logic glob_q, prev_q;
  logic [NUM_MODE_FIELDS-1:0][MODE_W-1:0] mode_q;
  csr_word_t word;
  logic unused_wr;

  assign wr_ok     = wr_en && wr_cond;
  assign unused_wr = ^{wr_data[31:10], wr_data[8]};

  csr_sat_sticky u_sat (
    .clk      (clk),
    .rst      (rst),
    .sat_evt  (sat_evt),
    .clr_req  (wr_ok && !wr_data[SAT_BIT]),
    .sat_pend (sat_pend),
    .sat_q    (sat_q)
  );

  for (genvar g = 0; g < NUM_MODE_FIELDS; g++) begin : g_mode
    localparam int unsigned LSB = mode_lsb(g);
    csr_mode_field #(.W(MODE_W)) u_field (
      .clk     (clk),
      .rst     (rst),
      .wr_ok   (wr_ok),
      .wr_val  (wr_data[LSB +: MODE_W]),
      .field_q (mode_q[g])
    );
  end

  csr_irq_enable u_irq (
    .clk     (clk),
    .rst     (rst),
    .wr_ok   (wr_ok),
    .wr_glob (wr_data[0]),
    .wr_prev (wr_data[1]),
    .take    (irq_take),
    .ret     (irq_return),
    .glob_q  (glob_q),
    .prev_q  (prev_q)
  );

  always_comb begin
    word.ident     = ID_VALUE;
    word.pwr_ctl   = '0;
    word.sat       = sat_q;
    word.endian    = LITTLE_ENDIAN;
    word.prog_mode = mode_q[1];
    word.data_mode = mode_q[0];
    word.prev_en   = prev_q;
    word.glob_en   = glob_q;
  end

  assign rd_data    = word;
  assign irq_enable = glob_q;

  // R9
  cond_false_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_cond && !sat_pend && !irq_take && !irq_return)
      |=> $stable(rd_data));

  // R12
  wr_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !irq_take && !irq_return) |=> (irq_enable == $past(wr_data[0])));
endmodule

// File: tb/sim_csr_ctrl_status.sv
module sim_csr_ctrl_status;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_cond, sat_evt, irq_take, irq_return;
  logic [31:0] wr_data;
  logic [31:0] rd_data, rd_be;
  logic        irq_enable, irq_enable_be;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  csr_ctrl_status u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cond(wr_cond), .wr_data(wr_data),
    .sat_evt(sat_evt), .irq_take(irq_take), .irq_return(irq_return),
    .rd_data(rd_data), .irq_enable(irq_enable));

  csr_ctrl_status #(.LITTLE_ENDIAN(1'b0)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cond(wr_cond), .wr_data(wr_data),
    .sat_evt(sat_evt), .irq_take(irq_take), .irq_return(irq_return),
    .rd_data(rd_be), .irq_enable(irq_enable_be));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one clock with the given inputs; starts and ends at a falling edge
  task automatic cyc(input logic en, input logic cond, input logic [31:0] d,
                     input logic s, input logic tk, input logic rt);
    wr_en = en; wr_cond = cond; wr_data = d; sat_evt = s;
    irq_take = tk; irq_return = rt;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; wr_cond = 0; wr_data = '0; sat_evt = 0; irq_take = 0; irq_return = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    cyc(1, 1, d, 0, 0, 0);
  endtask

  function automatic logic legal(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b010);
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] pm, dm;
    rst = 1; wr_en = 0; wr_cond = 0; wr_data = '0; sat_evt = 0; irq_take = 0; irq_return = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset word", rd_data, 32'h0203_0100);
    check("R1 reset irq_enable", {31'b0, irq_enable}, 32'h0);
    check("R4 big endian reset", rd_be, 32'h0203_0000);

    // R2 R3 R4: write ones over read-only and forced-zero bits
    wr(32'hFFFF_FC00);
    check("R2 R3 R4 read-only bits", rd_data, 32'h0203_0100);
    wr(32'h0000_0000);
    check("R4 endian write ignored", rd_data, 32'h0203_0100);
    check("R4 big endian kept", {31'b0, rd_be[8]}, 32'h0);
    for (int p = 0; p < 64; p++) begin
      wr({16'h0, p[5:0], 10'h000});
      check("R3 power bits zero", {26'b0, rd_data[15:10]}, 32'h0);
    end

    // R5: every pair of codes
    pm = 3'b000; dm = 3'b000;
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        wr({24'h0, a[2:0], b[2:0], 2'b00});
        if (legal(a[2:0])) pm = a[2:0];
        if (legal(b[2:0])) dm = b[2:0];
        check("R5 mode fields", {26'b0, rd_data[7:2]}, {26'b0, pm, dm});
      end
    end

    // R12 and R9
    wr(32'h0000_0049);   // prog mode 010, data mode 010, enable 1
    check("R12 write enable", rd_data, 32'h0203_0149);
    check("R12 irq_enable follows", {31'b0, irq_enable}, 32'h1);
    cyc(1, 0, 32'h0000_0002, 0, 0, 0);
    check("R9 false write ignored", rd_data, 32'h0203_0149);

    // R6 delayed set
    cyc(0, 0, '0, 1, 0, 0);
    check("R6 not yet set", {31'b0, rd_data[9]}, 32'h0);
    cyc(0, 0, '0, 0, 0, 0);
    check("R6 set one cycle later", {31'b0, rd_data[9]}, 32'h1);
    // R9 false clear of sat
    cyc(1, 0, 32'h0000_0049, 0, 0, 0);
    check("R9 false clear keeps sat", rd_data, 32'h0203_0349);
    // R7 clear
    wr(32'h0000_0049);
    check("R7 clear by write", {31'b0, rd_data[9]}, 32'h0);
    wr(32'h0000_0249);
    check("R7 write one does not set", {31'b0, rd_data[9]}, 32'h0);
    // R8 set beats clear
    cyc(0, 0, '0, 1, 0, 0);
    wr(32'h0000_0049);
    check("R8 set over clear", {31'b0, rd_data[9]}, 32'h1);
    wr(32'h0000_0049);
    check("R7 later clear", {31'b0, rd_data[9]}, 32'h0);

    // R10 nesting
    cyc(0, 0, '0, 0, 1, 0);
    check("R10 entry saves enable", {30'b0, rd_data[1:0]}, 32'h2);
    check("R10 irq_enable low", {31'b0, irq_enable}, 32'h0);
    wr(32'h0000_0003);
    cyc(0, 0, '0, 0, 1, 0);
    check("R10 nested entry", {30'b0, rd_data[1:0]}, 32'h2);
    cyc(0, 0, '0, 0, 0, 1);
    check("R11 return restores", {30'b0, rd_data[1:0]}, 32'h3);
    // R10 take beats write and return; cache field of the write applies
    cyc(1, 1, 32'h0000_0000, 0, 1, 1);
    check("R10 priority", rd_data, 32'h0203_0102);
    // R11 return beats write
    cyc(1, 1, 32'h0000_0000, 0, 0, 1);
    check("R11 return over write", {30'b0, rd_data[1:0]}, 32'h3);
    check("R11 irq_enable", {31'b0, irq_enable}, 32'h1);

    // R1 reset again clears everything
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 reset after use", rd_data, 32'h0203_0100);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule